// File: doc/BRIEF.md
# Key Combination Reset Detector

This block watches a small group of active-low key and power inputs. It issues system actions when a chosen set of keys is held down long enough. Four channels run side by side, and each one has its own settings. A channel can first require a separate guard pattern, such as the power button held down, to persist for a set time. Only after that does its main hold timer start. All timing is counted in ticks of a slow-clock enable, so one fast clock drives the whole block.

When a channel completes its hold, it sets its own sticky status bit. It also triggers any mix of four actions:
- a battery-cut level that stays on until reset;
- a one-cycle reset request;
- a one-cycle wake request;
- an active-low embedded-controller reset, stretched for a programmed number of ticks.

Configuration and status clearing arrive on plain ports. The register file lives elsewhere.

Top module: `kcombo_detect`

## Requirements
- R1: After reset, `combo_status` is 0, `bat_disable`, `rst_req` and `wake_req` are 0, and `ec_rst_n` is 1.
- R2: A key counts as active when its input bit is 0. A channel fires only after every key in its select mask has been active on max(D,1) consecutive ticks, where D is its hold count. With fewer ticks, it does not fire. Keys outside the mask have no effect.
- R3: A hold count or guard count of zero behaves as one tick.
- R4: When a channel's guard mask is non-zero, its hold ticks start counting only after every guarded key has been active on max(G,1) consecutive ticks, where G is its guard count. While the guard is unmet, the channel never fires. With a zero guard mask, the hold timer runs at once.
- R5: If a guarded key is released after the guard has been met, the channel goes back to waiting for the guard, and both timers start again.
- R6: A channel whose select mask is zero never fires, whatever the inputs.
- R7: After firing, a channel does not fire again until at least one selected key has been released.
- R8: Firing sets that channel's bit in `combo_status`. The bit stays set until a cycle with the matching `status_clr` bit high, and a fire in that same cycle keeps it set.
- R9: In each channel's 4-bit action field, bit 0 sets the sticky `bat_disable`, which only reset clears. Bit 1 gives one `rst_req` cycle per fire, and bit 2 gives one `wake_req` cycle per fire.
- R10: When a channel fires with action bit 3, `ec_rst_n` goes low and stays low for max(W,1) ticks, where W is `ec_width`.
- R11: Channels are independent: a fire on one channel sets only its own status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle slow-time enable that advances all timers |
| keys_n | input | NUM_IN | Debounced key and power inputs, active low |
| sel_mask | input | NUM_CH*NUM_IN | Per-channel hold key select |
| pre_mask | input | NUM_CH*NUM_IN | Per-channel guard key select |
| pre_ticks | input | NUM_CH*CNT_W | Per-channel guard duration in ticks |
| det_ticks | input | NUM_CH*CNT_W | Per-channel hold duration in ticks |
| act_mask | input | NUM_CH*4 | Per-channel action enables |
| ec_width | input | CNT_W | Embedded-controller reset width in ticks |
| status_clr | input | NUM_CH | Write-one clear of status bits |
| bat_disable | output | 1 | Sticky battery-cut level |
| rst_req | output | 1 | Reset request pulse |
| wake_req | output | 1 | Wake request pulse |
| ec_rst_n | output | 1 | Stretched active-low controller reset |
| combo_status | output | NUM_CH | Sticky per-channel fire status |

## Verification
The bench sweeps a two-key channel over hold counts 0 to 3 and hold lengths 0 to 4. This separates an exact threshold from an off-by-one, and shows the zero-count case acting as one tick. Stray unselected keys are mixed in to confirm that the mask is honoured. The bench also checks partial presses and, for a guarded channel, pressing the combo without the guard, pressing everything at once, and dropping the guard midway. These show whether the two phases run in sequence and whether they restart. Holding past a fire, then releasing and pressing again, separates single-shot behaviour from re-arming. Two stretch widths and a zero-mask channel under full key pressure cover the action outputs.

// File: rtl/kcombo_pkg.sv
// Shared constants and types for the key combination detector.
// Assumes a 4-bit action field per channel with the bit order below.
package kcombo_pkg;
    localparam int ACT_W    = 4;
    localparam int ACT_BAT  = 0;
    localparam int ACT_RST  = 1;
    localparam int ACT_WAKE = 2;
    localparam int ACT_EC   = 3;

    typedef enum logic [1:0] {
        CH_WAIT_PRE = 2'd0,
        CH_ARMED    = 2'd1,
        CH_HELD     = 2'd2
    } ch_state_e;
endpackage

// File: rtl/kcombo_channel.sv
// One detection channel: guard phase, then hold phase, then wait for release.
// Assumes keys_n is already debounced and tick is a single-cycle enable.
// The fire output is a registered one-cycle pulse on the cycle after the completing tick.
module kcombo_channel #(
    parameter int NUM_IN = 5,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [NUM_IN-1:0] keys_n,
    input  logic [NUM_IN-1:0] sel,
    input  logic [NUM_IN-1:0] pre_sel,
    input  logic [CNT_W-1:0]  pre_ticks,
    input  logic [CNT_W-1:0]  det_ticks,
    output logic              fire
);
    import kcombo_pkg::*;

    ch_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_inc;
    logic [CNT_W-1:0] pre_lim, det_lim;
    logic             combo_ok, pre_ok, no_pre, armed, pre_done, det_done;

    // Condition decode and limit computation (zero counts as one tick).
    always_comb begin
        combo_ok = (sel != '0) && ((keys_n & sel) == '0);
        pre_ok   = ((keys_n & pre_sel) == '0);
        no_pre   = (pre_sel == '0);
        armed    = (state == CH_ARMED) || ((state == CH_WAIT_PRE) && no_pre);
        pre_lim  = (pre_ticks == '0) ? CNT_W'(1) : pre_ticks;
        det_lim  = (det_ticks == '0) ? CNT_W'(1) : det_ticks;
        cnt_inc  = {1'b0, cnt} + (CNT_W+1)'(1);
        pre_done = cnt_inc >= {1'b0, pre_lim};
        det_done = cnt_inc >= {1'b0, det_lim};
    end

    // Phase sequencing and the shared tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CH_WAIT_PRE;
            cnt   <= '0;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (tick) begin
                if (armed) begin
                    if (!no_pre && !pre_ok) begin
                        state <= CH_WAIT_PRE;
                        cnt   <= '0;
                    end else if (combo_ok) begin
                        if (det_done) begin
                            fire  <= 1'b1;
                            state <= CH_HELD;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt_inc[CNT_W-1:0];
                        end
                    end else begin
                        cnt <= '0;
                    end
                end else if (state == CH_WAIT_PRE) begin
                    if (pre_ok) begin
                        if (pre_done) begin
                            state <= CH_ARMED;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt_inc[CNT_W-1:0];
                        end
                    end else begin
                        cnt <= '0;
                    end
                end else if (!combo_ok) begin
                    state <= CH_WAIT_PRE;
                    cnt   <= '0;
                end
            end
        end
    end

    // R2: a fire always follows a tick on which every selected key was active.
    a_r2_fire_on_held_tick: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(tick && sel != '0 && (keys_n & sel) == '0));
    // R4: a fire always follows a tick on which the guard pattern was met.
    a_r4_guard_met: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past((keys_n & pre_sel) == '0));
    // R7: the fire output is a single-cycle pulse.
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

// File: rtl/kcombo_status.sv
// Sticky per-channel status: set by a fire, cleared by a write-one pulse; set wins.
// Assumes fire and clr are single-clock-domain signals.
module kcombo_status #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] fire,
    input  logic [NUM_CH-1:0] clr,
    output logic [NUM_CH-1:0] status
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
        // Hold, set or clear one status bit.
        always_ff @(posedge clk) begin
            if (!rst_n)       status[i] <= 1'b0;
            else if (fire[i]) status[i] <= 1'b1;
            else if (clr[i])  status[i] <= 1'b0;
        end

        // R8: fire sets the bit on the next cycle.
        a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
            fire[i] |=> status[i]);
        // R8: clear without a fire empties the bit.
        a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !fire[i]) |=> !status[i]);
        // R8: a set bit stays set without a clear.
        a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !clr[i]) |=> status[i]);
    end
endmodule

// File: rtl/kcombo_actions.sv
// Merges channel fires into the system action outputs and stretches the controller reset.
// Assumes fire pulses are one cycle wide; a new stretch request reloads the width.
module kcombo_actions #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tick,
    input  logic [NUM_CH-1:0]              fire,
    input  logic [NUM_CH*kcombo_pkg::ACT_W-1:0] act_mask,
    input  logic [CNT_W-1:0]               ec_width,
    output logic                           bat_disable,
    output logic                           rst_req,
    output logic                           wake_req,
    output logic                           ec_rst_n
);
    import kcombo_pkg::*;

    logic [NUM_CH-1:0] hit_bat, hit_rst, hit_wake, hit_ec;
    logic [CNT_W-1:0]  rem;
    logic [CNT_W-1:0]  ec_lim;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        assign hit_bat[i]  = fire[i] & act_mask[i*ACT_W + ACT_BAT];
        assign hit_rst[i]  = fire[i] & act_mask[i*ACT_W + ACT_RST];
        assign hit_wake[i] = fire[i] & act_mask[i*ACT_W + ACT_WAKE];
        assign hit_ec[i]   = fire[i] & act_mask[i*ACT_W + ACT_EC];
    end

    assign rst_req  = |hit_rst;
    assign wake_req = |hit_wake;
    assign ec_lim   = (ec_width == '0) ? CNT_W'(1) : ec_width;
    assign ec_rst_n = (rem == '0);

    // Sticky battery-cut level.
    always_ff @(posedge clk) begin
        if (!rst_n)        bat_disable <= 1'b0;
        else if (|hit_bat) bat_disable <= 1'b1;
    end

    // Remaining ticks of the controller reset stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rem <= '0;
        else if (|hit_ec)           rem <= ec_lim;
        else if (tick && rem != '0) rem <= rem - CNT_W'(1);
    end

    // R9: the battery-cut level never drops outside reset.
    a_r9_bat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        bat_disable |=> bat_disable);
    // R10: the controller reset only starts after a fire that selects it.
    a_r10_ec_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ec_rst_n) |-> $past(|hit_ec));
    // R10: the stretch cannot end between ticks.
    a_r10_ec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ec_rst_n && !tick) |=> !ec_rst_n);
endmodule

// File: rtl/kcombo_detect.sv
// Top of the key combination detector: NUM_CH channels, sticky status, action merge.
// Assumes configuration is held stable while a channel is counting.
module kcombo_detect #(
    parameter int NUM_IN = 5,
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic [NUM_IN-1:0]         keys_n,
    input  logic [NUM_CH*NUM_IN-1:0]  sel_mask,
    input  logic [NUM_CH*NUM_IN-1:0]  pre_mask,
    input  logic [NUM_CH*CNT_W-1:0]   pre_ticks,
    input  logic [NUM_CH*CNT_W-1:0]   det_ticks,
    input  logic [NUM_CH*4-1:0]       act_mask,
    input  logic [CNT_W-1:0]          ec_width,
    input  logic [NUM_CH-1:0]         status_clr,
    output logic                      bat_disable,
    output logic                      rst_req,
    output logic                      wake_req,
    output logic                      ec_rst_n,
    output logic [NUM_CH-1:0]         combo_status
);
    logic [NUM_CH-1:0] fire;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        kcombo_channel #(.NUM_IN(NUM_IN), .CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .keys_n    (keys_n),
            .sel       (sel_mask[c*NUM_IN +: NUM_IN]),
            .pre_sel   (pre_mask[c*NUM_IN +: NUM_IN]),
            .pre_ticks (pre_ticks[c*CNT_W +: CNT_W]),
            .det_ticks (det_ticks[c*CNT_W +: CNT_W]),
            .fire      (fire[c])
        );
    end

    kcombo_status #(.NUM_CH(NUM_CH)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .clr    (status_clr),
        .status (combo_status)
    );

    kcombo_actions #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_act (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .fire        (fire),
        .act_mask    (act_mask),
        .ec_width    (ec_width),
        .bat_disable (bat_disable),
        .rst_req     (rst_req),
        .wake_req    (wake_req),
        .ec_rst_n    (ec_rst_n)
    );

    // R6 / R11: a status bit can only rise for a channel with a non-empty select mask.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        a_r6_empty_mask_silent: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(combo_status[c]) |-> $past(sel_mask[c*NUM_IN +: NUM_IN] != '0, 2));
    end
endmodule

// File: tb/tb_kcombo_detect.sv
`timescale 1ns/1ps
module tb_kcombo_detect;
    localparam int NI = 5;
    localparam int NC = 4;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [NI-1:0] keys_n = '1;
    logic [NC*NI-1:0] sel_mask = '0, pre_mask = '0;
    logic [NC*CW-1:0] pre_ticks = '0, det_ticks = '0;
    logic [NC*4-1:0] act_mask = '0;
    logic [CW-1:0] ec_width = '0;
    logic [NC-1:0] status_clr = '0;
    logic bat_disable, rst_req, wake_req, ec_rst_n;
    logic [NC-1:0] combo_status;

    int checks = 0, fails = 0;
    int rst_cnt = 0, wake_cnt = 0;
    int ec_low = 0;
    int rb, wb;

    always #2.5 clk = ~clk;

    kcombo_detect #(.NUM_IN(NI), .NUM_CH(NC), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .keys_n(keys_n),
        .sel_mask(sel_mask), .pre_mask(pre_mask), .pre_ticks(pre_ticks),
        .det_ticks(det_ticks), .act_mask(act_mask), .ec_width(ec_width),
        .status_clr(status_clr), .bat_disable(bat_disable), .rst_req(rst_req),
        .wake_req(wake_req), .ec_rst_n(ec_rst_n), .combo_status(combo_status)
    );

    // Pulse counters sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_req)  rst_cnt  <= rst_cnt + 1;
        if (wake_req) wake_cnt <= wake_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick = 1'b1;
            if (!ec_rst_n) ec_low++;
            @(negedge clk);
            tick = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; keys_n = '1; tick = 1'b0; status_clr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cfg_clear();
        sel_mask = '0; pre_mask = '0; pre_ticks = '0; det_ticks = '0;
        act_mask = '0; ec_width = '0;
    endtask

    task automatic pulse_clr(input logic [NC-1:0] m);
        @(negedge clk); status_clr = m;
        @(negedge clk); status_clr = '0;
        @(negedge clk);
    endtask

    initial begin
        #(1_000_000);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 status", int'(combo_status), 0);
        chk("R1 bat", int'(bat_disable), 0);
        chk("R1 rst_req", int'(rst_req), 0);
        chk("R1 wake_req", int'(wake_req), 0);
        chk("R1 ec_rst_n", int'(ec_rst_n), 1);

        // R2 / R3: sweep hold count and hold length on channel 0 (keys 0,1)
        for (int d = 0; d < 4; d++) begin
            for (int h = 0; h < 5; h++) begin
                int lim;
                cfg_clear();
                sel_mask[0 +: NI] = 5'b00011;
                det_ticks[0 +: CW] = CW'(d);
                act_mask[0 +: 4] = 4'b0010;
                do_reset();
                rb = rst_cnt;
                keys_n = (h % 2 == 1) ? 5'b11100 : 5'b01100;
                do_ticks(h);
                lim = (d == 0) ? 1 : d;
                chk((d == 0) ? "R3 zero hold status" : "R2 hold status",
                    int'(combo_status[0]), (h >= lim) ? 1 : 0);
                chk("R2 rst_req pulses", rst_cnt - rb, (h >= lim) ? 1 : 0);
            end
        end

        // R2: partial press never fires
        cfg_clear();
        sel_mask[0 +: NI] = 5'b00011; det_ticks[0 +: CW] = 16'd1;
        do_reset();
        keys_n = 5'b11110;
        do_ticks(6);
        chk("R2 partial press", int'(combo_status), 0);

        // R4: guarded channel 1, guard key 4, G=2, D=2, wake action
        cfg_clear();
        sel_mask[NI +: NI] = 5'b00011; pre_mask[NI +: NI] = 5'b10000;
        pre_ticks[CW +: CW] = 16'd2; det_ticks[CW +: CW] = 16'd2;
        act_mask[4 +: 4] = 4'b0100;
        do_reset();
        keys_n = 5'b11100;
        do_ticks(10);
        chk("R4 no guard no fire", int'(combo_status), 0);
        do_reset();
        wb = wake_cnt;
        keys_n = 5'b01100;
        do_ticks(3);
        chk("R4 three ticks not enough", int'(combo_status[1]), 0);
        do_ticks(1);
        chk("R4 fires after guard plus hold", int'(combo_status[1]), 1);
        chk("R9 wake pulse", wake_cnt - wb, 1);

        // R5: drop guard after arming, then restart both timers
        do_reset();
        keys_n = 5'b01100;
        do_ticks(3);
        keys_n = 5'b11100;
        do_ticks(1);
        keys_n = 5'b01100;
        do_ticks(3);
        chk("R5 restart needs full guard again", int'(combo_status[1]), 0);
        do_ticks(1);
        chk("R5 fires after restart", int'(combo_status[1]), 1);

        // R6: empty select mask, all keys pressed
        cfg_clear();
        act_mask = '1; pre_mask = '0;
        do_reset();
        rb = rst_cnt; wb = wake_cnt;
        keys_n = 5'b00000;
        do_ticks(10);
        chk("R6 status", int'(combo_status), 0);
        chk("R6 pulses", (rst_cnt - rb) + (wake_cnt - wb), 0);
        chk("R6 ec_rst_n", int'(ec_rst_n), 1);
        chk("R6 bat", int'(bat_disable), 0);

        // R7 / R8: single shot, sticky status, clear, re-arm
        cfg_clear();
        sel_mask[0 +: NI] = 5'b00011; det_ticks[0 +: CW] = 16'd1;
        act_mask[0 +: 4] = 4'b0010;
        do_reset();
        rb = rst_cnt;
        keys_n = 5'b11100;
        do_ticks(1);
        chk("R8 set", int'(combo_status[0]), 1);
        do_ticks(4);
        chk("R8 sticky", int'(combo_status[0]), 1);
        pulse_clr(4'b0001);
        chk("R8 cleared", int'(combo_status[0]), 0);
        do_ticks(5);
        chk("R7 no refire while held", int'(combo_status[0]), 0);
        chk("R7 one pulse while held", rst_cnt - rb, 1);
        keys_n = 5'b11110;
        do_ticks(1);
        keys_n = 5'b11100;
        do_ticks(1);
        chk("R7 refire after release", int'(combo_status[0]), 1);
        chk("R7 second pulse", rst_cnt - rb, 2);

        // R9 / R10: channel 3, key 2, battery + stretch, W=3
        cfg_clear();
        sel_mask[3*NI +: NI] = 5'b00100; det_ticks[3*CW +: CW] = 16'd1;
        act_mask[12 +: 4] = 4'b1001; ec_width = 16'd3;
        do_reset();
        rb = rst_cnt; wb = wake_cnt;
        keys_n = 5'b11011;
        do_ticks(1);
        ec_low = 0;
        keys_n = 5'b11111;
        do_ticks(6);
        chk("R10 stretch of 3 ticks", ec_low, 3);
        chk("R10 released", int'(ec_rst_n), 1);
        chk("R9 bat sticky", int'(bat_disable), 1);
        chk("R9 no rst or wake", (rst_cnt - rb) + (wake_cnt - wb), 0);
        chk("R11 only channel 3", int'(combo_status), 8);
        ec_width = 16'd0;
        keys_n = 5'b11011;
        do_ticks(1);
        ec_low = 0;
        keys_n = 5'b11111;
        do_ticks(4);
        chk("R10 zero width is one tick", ec_low, 1);

        // R11: two channels, press only channel 0 keys
        cfg_clear();
        sel_mask[0 +: NI] = 5'b00011; sel_mask[3*NI +: NI] = 5'b00100;
        det_ticks[0 +: CW] = 16'd1; det_ticks[3*CW +: CW] = 16'd1;
        do_reset();
        keys_n = 5'b11100;
        do_ticks(2);
        chk("R11 independent channels", int'(combo_status), 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule